// File: doc/BRIEF.md
# Transaction-Aware Warp Reconvergence Stack

This block tracks control flow for one warp of a SIMT core. It keeps a stack of entries, each holding an entry kind, a next PC, a reconvergence PC and a per-lane active mask. The top entry drives the PC the warp fetches from and the lanes that execute. Ordinary branches split the warp into taken and not-taken groups, and those groups meet again at the reconvergence PC. Straight-line progress is reported as a step to the next PC.

The stack also supports transactions. When a transaction opens, two entries are pushed. The lower one is a retry entry that collects the lanes that will have to run again. The upper one is a transaction entry holding the lanes that execute the transaction now. At commit, lanes that failed validation are merged into the retry entry. If any lanes failed, they restart at the first instruction of the transaction, and they are the only lanes active. If none failed, both entries leave the stack and the warp resumes after the transaction.

The transaction logic sits on the same stack as ordinary divergence, so branches inside a transaction nest above the transaction entry and reconverge at the commit point.

Top module: `txn_simt_stack`

## Requirements
- R1: After reset the top PC equals RESET_PC, the top mask has every lane set, and the overflow flag is 0.
- R2: A step sets the top entry's PC to the reported next PC. If that PC equals the top entry's reconvergence PC and the entry is not the last one, the entry is popped, and the entry beneath supplies the top PC and mask.
- R3: A branch whose taken mask (bit i is lane i) splits the active lanes does three things. It sets the current entry's PC to the branch reconvergence PC. It pushes a not-taken entry at the fall-through PC. It then pushes a taken entry at the target PC above it. The taken lanes execute first.
- R4: A branch whose active lanes all go the same way pushes nothing. The top PC moves to the target if the lanes are taken, or to the fall-through PC if they are not.
- R5: A transaction begin does three things. It sets the current entry's PC to the post-transaction PC. It pushes a retry entry with an empty mask at the start PC. It then pushes a transaction entry at the start PC with the current active mask. The top then shows the start PC with the mask unchanged.
- R6: A commit while a transaction entry is on top ORs the failed lanes that were active into the retry entry. If the result is nonzero, then in the same cycle the top shows the start PC with exactly those lanes, and the retry mask returns to zero.
- R7: A commit with no active lane failing pops both the transaction entry and the retry entry. The warp continues at the post-transaction PC with the mask it had before the transaction.
- R8: A commit while the top entry is not a transaction entry has no effect.
- R9: An event needing two pushes when fewer than two slots remain in the DEPTH-entry stack is dropped, and it sets the overflow flag. The flag stays set until reset.
- R10: When several events are valid in one cycle, the block acts on exactly one of them. The order of precedence is: an accepted commit, then transaction begin, then branch, then step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| stepValid | input | 1 | Warp advanced without branching |
| stepPc | input | PC_W | Next PC for a step |
| brValid | input | 1 | Branch resolved this cycle |
| brTakenMask | input | LANES | Lanes whose branch is taken, bit i is lane i |
| brTargetPc | input | PC_W | Branch target PC |
| brFallPc | input | PC_W | Fall-through PC |
| brRpc | input | PC_W | Reconvergence PC of the branch |
| txBeginValid | input | 1 | Transaction opens |
| txStartPc | input | PC_W | First instruction of the transaction |
| txEndPc | input | PC_W | PC following the transaction |
| txCommitValid | input | 1 | Transaction commit with validation result |
| txFailMask | input | LANES | Lanes that failed validation |
| topPc | output | PC_W | PC of the top entry |
| topMask | output | LANES | Active lanes of the top entry |
| overflow | output | 1 | Sticky stack overflow flag |

## Verification
Two things share a single cycle at commit: the failed lanes are merged into the retry entry, and the transaction restarts with the merged mask. The bench provokes this by committing with a failure mask that names two active lanes and one inactive lane. One edge later it judges that the top PC is the transaction start and that the mask holds only the active failed lanes. A second commit with no failures must then uncover the path entry beneath in one step. Simultaneous strobes are also driven, to confirm that only the highest-priority event takes effect.

// File: rtl/tss_pkg.sv
package tss_pkg;

  typedef enum logic [1:0] {
    KIND_NORMAL = 2'd0,
    KIND_RETRY  = 2'd1,
    KIND_TXN    = 2'd2
  } entKind_e;

  // strobes from control to storage; at most one stack move per cycle
  typedef struct packed {
    logic wrTopPc;
    logic wrTopMask;
    logic clrBelowMask;
    logic pop1;
    logic pop2;
    logic push2;
    logic setOvf;
  } stackCmd_t;

endpackage

// File: rtl/tss_datapath.sv
module tss_datapath
  import tss_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned LANES = 8,
  parameter int unsigned DEPTH = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0,
  localparam int unsigned SP_W  = $clog2(DEPTH + 1),
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  stackCmd_t        cmd,
  input  logic [PC_W-1:0]  newTopPc,
  input  logic [LANES-1:0] newTopMask,
  input  entKind_e         loKind,
  input  logic [PC_W-1:0]  loPc,
  input  logic [PC_W-1:0]  loRpc,
  input  logic [LANES-1:0] loMask,
  input  entKind_e         hiKind,
  input  logic [PC_W-1:0]  hiPc,
  input  logic [PC_W-1:0]  hiRpc,
  input  logic [LANES-1:0] hiMask,
  output entKind_e         topKind,
  output logic [PC_W-1:0]  topPc,
  output logic [PC_W-1:0]  topRpc,
  output logic [LANES-1:0] topMask,
  output logic [PC_W-1:0]  belowPc,
  output logic [LANES-1:0] belowMask,
  output logic [SP_W-1:0]  depth,
  output logic             overflow
);

  localparam logic [PC_W-1:0] NO_RPC = {PC_W{1'b1}};

  entKind_e         kindQ [DEPTH];
  logic [PC_W-1:0]  pcQ   [DEPTH];
  logic [PC_W-1:0]  rpcQ  [DEPTH];
  logic [LANES-1:0] maskQ [DEPTH];
  logic [SP_W-1:0]  spQ;
  logic             ovfQ;

  logic [IDX_W-1:0] topIdx;
  logic [IDX_W-1:0] belowIdx;
  logic [IDX_W-1:0] pushLoIdx;
  logic [IDX_W-1:0] pushHiIdx;
  entKind_e         belowKind;

  assign topIdx    = IDX_W'(spQ - SP_W'(1));
  assign belowIdx  = (spQ > SP_W'(1)) ? IDX_W'(spQ - SP_W'(2)) : '0;
  assign pushLoIdx = IDX_W'(spQ);
  assign pushHiIdx = IDX_W'(spQ + SP_W'(1));

  assign topKind   = kindQ[topIdx];
  assign topPc     = pcQ[topIdx];
  assign topRpc    = rpcQ[topIdx];
  assign topMask   = maskQ[topIdx];
  assign belowKind = kindQ[belowIdx];
  assign belowPc   = pcQ[belowIdx];
  assign belowMask = maskQ[belowIdx];
  assign depth     = spQ;
  assign overflow  = ovfQ;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        kindQ[i] <= KIND_NORMAL;
        pcQ[i]   <= '0;
        rpcQ[i]  <= NO_RPC;
        maskQ[i] <= '0;
      end
      pcQ[0]   <= RESET_PC;
      maskQ[0] <= '1;
      spQ      <= SP_W'(1);
      ovfQ     <= 1'b0;
    end else begin
      if (cmd.wrTopPc)      pcQ[topIdx]     <= newTopPc;
      if (cmd.wrTopMask)    maskQ[topIdx]   <= newTopMask;
      if (cmd.clrBelowMask) maskQ[belowIdx] <= '0;
      if (cmd.push2) begin
        kindQ[pushLoIdx] <= loKind;
        pcQ[pushLoIdx]   <= loPc;
        rpcQ[pushLoIdx]  <= loRpc;
        maskQ[pushLoIdx] <= loMask;
        kindQ[pushHiIdx] <= hiKind;
        pcQ[pushHiIdx]   <= hiPc;
        rpcQ[pushHiIdx]  <= hiRpc;
        maskQ[pushHiIdx] <= hiMask;
        spQ              <= spQ + SP_W'(2);
      end else if (cmd.pop1) begin
        spQ <= spQ - SP_W'(1);
      end else if (cmd.pop2) begin
        spQ <= spQ - SP_W'(2);
      end
      if (cmd.setOvf) ovfQ <= 1'b1;
    end
  end

  // R9: the occupied count never leaves 1..DEPTH
  assert_depth_bounds_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spQ >= SP_W'(1)) && (spQ <= SP_W'(DEPTH)));

  // R9: overflow flag is sticky
  assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ovfQ |=> ovfQ);

  // R5: a transaction entry always sits directly on its retry entry
  assert_txn_over_retry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (topKind == KIND_TXN) |-> (spQ > SP_W'(1)) && (belowKind == KIND_RETRY));

  // R6: the lanes shown at the top are never empty
  assert_top_mask_live_R6: assert property (@(posedge clk) disable iff (!rst_n)
    topMask != '0);

endmodule

// File: rtl/tss_ctrl.sv
module tss_ctrl
  import tss_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned LANES = 8,
  parameter int unsigned DEPTH = 16,
  localparam int unsigned SP_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stepValid,
  input  logic [PC_W-1:0]  stepPc,
  input  logic             brValid,
  input  logic [LANES-1:0] brTakenMask,
  input  logic [PC_W-1:0]  brTargetPc,
  input  logic [PC_W-1:0]  brFallPc,
  input  logic [PC_W-1:0]  brRpc,
  input  logic             txBeginValid,
  input  logic [PC_W-1:0]  txStartPc,
  input  logic [PC_W-1:0]  txEndPc,
  input  logic             txCommitValid,
  input  logic [LANES-1:0] txFailMask,
  input  entKind_e         topKind,
  input  logic [PC_W-1:0]  topRpc,
  input  logic [LANES-1:0] topMask,
  input  logic [PC_W-1:0]  belowPc,
  input  logic [LANES-1:0] belowMask,
  input  logic [SP_W-1:0]  depth,
  output stackCmd_t        cmd,
  output logic [PC_W-1:0]  newTopPc,
  output logic [LANES-1:0] newTopMask,
  output entKind_e         loKind,
  output logic [PC_W-1:0]  loPc,
  output logic [PC_W-1:0]  loRpc,
  output logic [LANES-1:0] loMask,
  output entKind_e         hiKind,
  output logic [PC_W-1:0]  hiPc,
  output logic [PC_W-1:0]  hiRpc,
  output logic [LANES-1:0] hiMask
);

  localparam logic [PC_W-1:0] NO_RPC = {PC_W{1'b1}};

  logic             room2;
  logic             commitTake;
  logic [LANES-1:0] mergedRetry;
  logic [LANES-1:0] takenLanes;
  logic [LANES-1:0] fallLanes;
  logic             moveReq;
  logic [PC_W-1:0]  movePc;

  assign room2       = depth <= SP_W'(DEPTH - 2);
  assign commitTake  = txCommitValid && (topKind == KIND_TXN);
  assign mergedRetry = belowMask | (txFailMask & topMask);
  assign takenLanes  = topMask & brTakenMask;
  assign fallLanes   = topMask & ~brTakenMask;

  always_comb begin
    cmd        = '0;
    newTopPc   = '0;
    newTopMask = '0;
    loKind     = KIND_NORMAL;
    loPc       = '0;
    loRpc      = NO_RPC;
    loMask     = '0;
    hiKind     = KIND_NORMAL;
    hiPc       = '0;
    hiRpc      = NO_RPC;
    hiMask     = '0;
    moveReq    = 1'b0;
    movePc     = stepPc;

    if (commitTake) begin
      if (mergedRetry != '0) begin
        // restart failed lanes at the transaction start, retry emptied
        cmd.wrTopPc      = 1'b1;
        cmd.wrTopMask    = 1'b1;
        cmd.clrBelowMask = 1'b1;
        newTopPc         = belowPc;
        newTopMask       = mergedRetry;
      end else begin
        cmd.pop2 = 1'b1;
      end
    end else if (txBeginValid) begin
      if (room2) begin
        cmd.wrTopPc = 1'b1;
        newTopPc    = txEndPc;
        cmd.push2   = 1'b1;
        loKind      = KIND_RETRY;
        loPc        = txStartPc;
        loMask      = '0;
        hiKind      = KIND_TXN;
        hiPc        = txStartPc;
        hiMask      = topMask;
      end else begin
        cmd.setOvf = 1'b1;
      end
    end else if (brValid) begin
      if ((takenLanes != '0) && (fallLanes != '0)) begin
        if (room2) begin
          cmd.wrTopPc = 1'b1;
          newTopPc    = brRpc;
          cmd.push2   = 1'b1;
          loKind      = KIND_NORMAL;
          loPc        = brFallPc;
          loRpc       = brRpc;
          loMask      = fallLanes;
          hiKind      = KIND_NORMAL;
          hiPc        = brTargetPc;
          hiRpc       = brRpc;
          hiMask      = takenLanes;
        end else begin
          cmd.setOvf = 1'b1;
        end
      end else begin
        moveReq = 1'b1;
        movePc  = (takenLanes != '0) ? brTargetPc : brFallPc;
      end
    end else if (stepValid) begin
      moveReq = 1'b1;
      movePc  = stepPc;
    end

    if (moveReq) begin
      if ((movePc == topRpc) && (depth > SP_W'(1))) begin
        cmd.pop1 = 1'b1;
      end else begin
        cmd.wrTopPc = 1'b1;
        newTopPc    = movePc;
      end
    end
  end

  // R10: only one stack movement per cycle
  assert_single_move_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd.push2, cmd.pop1, cmd.pop2}));

  // R5: an accepted transaction begin leaves the visible mask unchanged
  assert_begin_keeps_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (txBeginValid && !commitTake && room2) |=> (topMask == $past(topMask)));

endmodule

// File: rtl/txn_simt_stack.sv
module txn_simt_stack
  import tss_pkg::*;
#(
  parameter int unsigned PC_W  = 32,
  parameter int unsigned LANES = 8,
  parameter int unsigned DEPTH = 16,
  parameter logic [PC_W-1:0] RESET_PC = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stepValid,
  input  logic [PC_W-1:0]  stepPc,
  input  logic             brValid,
  input  logic [LANES-1:0] brTakenMask,
  input  logic [PC_W-1:0]  brTargetPc,
  input  logic [PC_W-1:0]  brFallPc,
  input  logic [PC_W-1:0]  brRpc,
  input  logic             txBeginValid,
  input  logic [PC_W-1:0]  txStartPc,
  input  logic [PC_W-1:0]  txEndPc,
  input  logic             txCommitValid,
  input  logic [LANES-1:0] txFailMask,
  output logic [PC_W-1:0]  topPc,
  output logic [LANES-1:0] topMask,
  output logic             overflow
);

  localparam int unsigned SP_W = $clog2(DEPTH + 1);

  stackCmd_t        cmd;
  logic [PC_W-1:0]  newTopPc;
  logic [LANES-1:0] newTopMask;
  entKind_e         loKind;
  logic [PC_W-1:0]  loPc;
  logic [PC_W-1:0]  loRpc;
  logic [LANES-1:0] loMask;
  entKind_e         hiKind;
  logic [PC_W-1:0]  hiPc;
  logic [PC_W-1:0]  hiRpc;
  logic [LANES-1:0] hiMask;
  entKind_e         topKind;
  logic [PC_W-1:0]  topRpc;
  logic [PC_W-1:0]  belowPc;
  logic [LANES-1:0] belowMask;
  logic [SP_W-1:0]  depth;

  tss_ctrl #(.PC_W(PC_W), .LANES(LANES), .DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .stepValid(stepValid), .stepPc(stepPc),
    .brValid(brValid), .brTakenMask(brTakenMask), .brTargetPc(brTargetPc),
    .brFallPc(brFallPc), .brRpc(brRpc),
    .txBeginValid(txBeginValid), .txStartPc(txStartPc), .txEndPc(txEndPc),
    .txCommitValid(txCommitValid), .txFailMask(txFailMask),
    .topKind(topKind), .topRpc(topRpc), .topMask(topMask),
    .belowPc(belowPc), .belowMask(belowMask), .depth(depth),
    .cmd(cmd), .newTopPc(newTopPc), .newTopMask(newTopMask),
    .loKind(loKind), .loPc(loPc), .loRpc(loRpc), .loMask(loMask),
    .hiKind(hiKind), .hiPc(hiPc), .hiRpc(hiRpc), .hiMask(hiMask)
  );

  tss_datapath #(.PC_W(PC_W), .LANES(LANES), .DEPTH(DEPTH), .RESET_PC(RESET_PC)) u_dp (
    .clk(clk), .rst_n(rst_n), .cmd(cmd),
    .newTopPc(newTopPc), .newTopMask(newTopMask),
    .loKind(loKind), .loPc(loPc), .loRpc(loRpc), .loMask(loMask),
    .hiKind(hiKind), .hiPc(hiPc), .hiRpc(hiRpc), .hiMask(hiMask),
    .topKind(topKind), .topPc(topPc), .topRpc(topRpc), .topMask(topMask),
    .belowPc(belowPc), .belowMask(belowMask), .depth(depth),
    .overflow(overflow)
  );

endmodule

// File: tb/txn_simt_stack_test.sv
`timescale 1ns/1ps
module txn_simt_stack_test;

  localparam int PC_W  = 32;
  localparam int LANES = 8;
  localparam int DEPTH = 16;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             stepValid;
  logic [PC_W-1:0]  stepPc;
  logic             brValid;
  logic [LANES-1:0] brTakenMask;
  logic [PC_W-1:0]  brTargetPc;
  logic [PC_W-1:0]  brFallPc;
  logic [PC_W-1:0]  brRpc;
  logic             txBeginValid;
  logic [PC_W-1:0]  txStartPc;
  logic [PC_W-1:0]  txEndPc;
  logic             txCommitValid;
  logic [LANES-1:0] txFailMask;
  logic [PC_W-1:0]  topPc;
  logic [LANES-1:0] topMask;
  logic             overflow;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  txn_simt_stack #(.PC_W(PC_W), .LANES(LANES), .DEPTH(DEPTH), .RESET_PC(32'h0)) uut (
    .clk(clk), .rst_n(rst_n),
    .stepValid(stepValid), .stepPc(stepPc),
    .brValid(brValid), .brTakenMask(brTakenMask), .brTargetPc(brTargetPc),
    .brFallPc(brFallPc), .brRpc(brRpc),
    .txBeginValid(txBeginValid), .txStartPc(txStartPc), .txEndPc(txEndPc),
    .txCommitValid(txCommitValid), .txFailMask(txFailMask),
    .topPc(topPc), .topMask(topMask), .overflow(overflow)
  );

  task automatic clearIn();
    stepValid = 0; stepPc = '0;
    brValid = 0; brTakenMask = '0; brTargetPc = '0; brFallPc = '0; brRpc = '0;
    txBeginValid = 0; txStartPc = '0; txEndPc = '0;
    txCommitValid = 0; txFailMask = '0;
  endtask

  task automatic tick();
    @(posedge clk); #1;
    clearIn();
  endtask

  task automatic check(string req, logic [PC_W-1:0] ePc, logic [LANES-1:0] eMask, logic eOvf);
    checks++;
    if (topPc !== ePc || topMask !== eMask || overflow !== eOvf) begin
      fails++;
      $display("FAIL %s: actual pc=%h mask=%b ovf=%b expected pc=%h mask=%b ovf=%b",
               req, topPc, topMask, overflow, ePc, eMask, eOvf);
    end
  endtask

  task automatic doStep(logic [PC_W-1:0] pc);
    stepValid = 1; stepPc = pc; tick();
  endtask

  task automatic doBranch(logic [LANES-1:0] tm, logic [PC_W-1:0] tgt,
                          logic [PC_W-1:0] fall, logic [PC_W-1:0] rpc);
    brValid = 1; brTakenMask = tm; brTargetPc = tgt; brFallPc = fall; brRpc = rpc; tick();
  endtask

  task automatic doBegin(logic [PC_W-1:0] s, logic [PC_W-1:0] e);
    txBeginValid = 1; txStartPc = s; txEndPc = e; tick();
  endtask

  task automatic doCommit(logic [LANES-1:0] f);
    txCommitValid = 1; txFailMask = f; tick();
  endtask

  task automatic applyReset();
    clearIn();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
  endtask

  task automatic t_reset();
    applyReset();
    check("R1", 32'h0, 8'hFF, 1'b0);
  endtask

  task automatic t_diverge_txn();
    doStep(32'h8);
    check("R2 step", 32'h8, 8'hFF, 1'b0);
    doBranch(8'hF3, 32'h10, 32'h80, 32'h90);
    check("R3 taken first", 32'h10, 8'hF3, 1'b0);
    doBegin(32'h14, 32'h40);
    check("R5 begin", 32'h14, 8'hF3, 1'b0);
    doBranch(8'h13, 32'h20, 32'h18, 32'h30);
    check("R3 inner taken", 32'h20, 8'h13, 1'b0);
    doStep(32'h30);
    check("R2 pop to fall path", 32'h18, 8'hE0, 1'b0);
    doStep(32'h30);
    check("R2 pop to txn entry", 32'h30, 8'hF3, 1'b0);
    // lanes 6,7 fail; lane 2 is inactive and must be ignored
    doCommit(8'hC4);
    check("R6 restart failed lanes", 32'h14, 8'hC0, 1'b0);
    doBranch(8'h00, 32'h20, 32'h18, 32'h30);
    check("R4 uniform not taken", 32'h18, 8'hC0, 1'b0);
    doBranch(8'hC0, 32'h24, 32'h1C, 32'h30);
    check("R4 uniform taken", 32'h24, 8'hC0, 1'b0);
    doStep(32'h30);
    check("R2 no pop at txn entry", 32'h30, 8'hC0, 1'b0);
    doCommit(8'h00);
    check("R7 commit all", 32'h40, 8'hF3, 1'b0);
    doStep(32'h90);
    check("R2 pop to not-taken", 32'h80, 8'h0C, 1'b0);
    doStep(32'h90);
    check("R2 pop to base", 32'h90, 8'hFF, 1'b0);
  endtask

  task automatic t_ignore_commit();
    doCommit(8'hFF);
    check("R8 commit ignored", 32'h90, 8'hFF, 1'b0);
  endtask

  task automatic t_priority();
    txBeginValid = 1; txStartPc = 32'h200; txEndPc = 32'h300;
    stepValid = 1; stepPc = 32'h500;
    tick();
    check("R10 begin over step", 32'h200, 8'hFF, 1'b0);
    txCommitValid = 1; txFailMask = 8'h00;
    brValid = 1; brTakenMask = 8'h0F; brTargetPc = 32'h600; brFallPc = 32'h604; brRpc = 32'h608;
    stepValid = 1; stepPc = 32'h700;
    tick();
    check("R10 commit over branch", 32'h300, 8'hFF, 1'b0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < (DEPTH - 1) / 2; i++) begin
      doBegin(32'h1000 + 32'(i) * 32'h10, 32'h2000 + 32'(i) * 32'h10);
    end
    check("R9 full not flagged", 32'h1060, 8'hFF, 1'b0);
    doBegin(32'h3000, 32'h3100);
    check("R9 overflow dropped", 32'h1060, 8'hFF, 1'b1);
    doBranch(8'h0F, 32'h3200, 32'h3204, 32'h3208);
    check("R9 split dropped sticky", 32'h1060, 8'hFF, 1'b1);
    doStep(32'h1064);
    check("R9 sticky", 32'h1064, 8'hFF, 1'b1);
  endtask

  initial begin
    t_reset();
    t_diverge_txn();
    t_ignore_commit();
    t_priority();
    t_overflow();
    t_reset();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual still running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule